// File: doc/BRIEF.md
# SCSI Initiator Byte-Transfer Handshake Engine

This block moves a programmed number of bytes across a parallel SCSI bus from the initiator side, while the target owns the phase lines and paces every byte with REQ. A transfer begins with a one-cycle `start` pulse, which also supplies the direction and the byte count. The engine then records the bus phase. Each byte follows the REQ/ACK interlock. Received bytes come out on a strobed stream. Bytes to send are taken from a presented byte, and `tx_take` advances the source to the next one.

The engine stops early in three cases. The first is when the phase lines stop matching the recorded phase. The second is when REQ fails to reach the expected level within a cycle budget. The third is when the bus reset line is raised. In every case it releases ACK, pulses `done`, and holds the number of completed bytes and two error flags until the next start. When the recorded phase is message-out on a send, the engine drives ATN for the transfer and lets go of it as soon as REQ appears for the final byte.

Top module: `scsi_init_xfer`

## Requirements
- R1: After reset, `bus_ack`, `bus_atn`, `bus_db_oe`, `busy`, `done`, `err_phase`, `err_timeout` and `xfer_count` are all 0.
- R2: On a receive (`dir_rx`=1), once REQ is sampled high the engine waits SETTLE_CYC further cycles. It then copies `bus_db_in` to `rx_data`, pulses `rx_valid`, and raises ACK. ACK is first visible SETTLE_CYC+1 rising edges after REQ rose, counting the edge that sampled REQ.
- R3: On a send (`dir_rx`=0), `bus_db_oe` is 1 and `bus_db_out` equals `tx_data` for the whole transfer. ACK rises on the edge that first samples REQ high. `tx_take` pulses once for each completed byte.
- R4: ACK is released on the edge that samples REQ low. That byte then counts as completed, and the next byte's REQ wait begins.
- R5: The phase `{MSG, C/D, I/O}` is recorded at start. If it differs from the recorded value when REQ is sampled high, the transfer ends without ACK for that byte, with `err_phase`=1.
- R6: After a non-final byte completes, a phase that differs from the recorded value ends the transfer with `err_phase`=1. The completed byte is included in `xfer_count`. The final byte is exempt from this check.
- R7: On a send whose recorded phase is message-out (3'b110), `bus_atn` is 1 from start. It drops on the edge that samples REQ high for the last byte, so ATN is already 0 when ACK rises for that byte.
- R8: If REQ does not change within TIMEOUT_CYC cycles of waiting, the transfer ends with `err_timeout`=1. It does not end earlier.
- R9: If REQ stays high after ACK, the timeout ends the transfer with ACK released, and that byte is not counted.
- R10: `bus_rst` high during any wait ends the transfer on the next edge with `err_timeout`=1 and ACK released.
- R11: `done` is a one-cycle pulse, exactly once per transfer. A start with a count of 0 finishes at once with `done`, a count of 0 and no error.
- R12: `xfer_count` is the number of completed bytes. `xfer_count` and both error flags hold their values until the next start, and at most one error flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (sampled while idle) |
| dir_rx | input | 1 | 1 = receive from target, 0 = send to target |
| xfer_len | input | CNT_W | Number of bytes to transfer |
| tx_data | input | 8 | Byte to send next |
| tx_take | output | 1 | Pulse: current send byte is done, present the next |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | Pulse: `rx_data` holds a new byte |
| bus_db_in | input | 8 | Data lines as seen on the bus |
| bus_db_out | output | 8 | Data driven onto the bus |
| bus_db_oe | output | 1 | Drive enable for `bus_db_out` |
| bus_phase | input | 3 | Phase lines {MSG, C/D, I/O} |
| bus_req | input | 1 | Target REQ, active high |
| bus_rst | input | 1 | Bus reset, active high |
| bus_ack | output | 1 | Initiator ACK, active high |
| bus_atn | output | 1 | Initiator ATN, active high |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| xfer_count | output | CNT_W | Completed bytes |
| err_phase | output | 1 | Transfer ended on a phase mismatch |
| err_timeout | output | 1 | Transfer ended on a REQ timeout or bus reset |

## Verification
The hardest case to reach from the ports is a phase change caught by the check that follows a byte, not the check taken when REQ rises. The phase lines must change in the same cycle that REQ falls. If they change even one cycle later, the check at the next REQ rise catches the mismatch instead. The bench's target model therefore flips the phase at the exact edge where it releases REQ for the chosen byte, and in a separate vector flips it together with REQ rising. Stuck-high REQ is produced by raising REQ and never lowering it, which drives the engine into the timeout on the ACK side.

// File: rtl/scsi_xfer_pkg.sv
package scsi_xfer_pkg;

    typedef logic [2:0] bus_phase_t;   // {MSG, C/D, I/O}

    localparam bus_phase_t PH_MSG_OUT = 3'b110;

    typedef enum logic [1:0] {
        XS_IDLE,
        XS_WAIT_HI,
        XS_SETTLE,
        XS_WAIT_LO
    } xfer_state_e;

    typedef enum logic [1:0] {
        END_OK,
        END_PHASE,
        END_TIMEOUT
    } end_cause_e;

    typedef struct packed {
        logic err_phase;
        logic err_timeout;
    } xfer_status_t;

    function automatic logic owns_atn(input logic rx, input bus_phase_t ph);
        return !rx && (ph == PH_MSG_OUT);
    endfunction

endpackage

// File: rtl/scsi_xfer_timer.sv
module scsi_xfer_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);

    logic [W-1:0] cnt;

    assign expired = run && (cnt == W'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt <= '0;
        else if (run && !expired)
            cnt <= cnt + 1'b1;
    end

    AST_TMR_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= W'(LIMIT - 1)); // R8

endmodule

// File: rtl/scsi_xfer_phase_lock.sv
module scsi_xfer_phase_lock
    import scsi_xfer_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       capture,
    input  bus_phase_t phase_in,
    output bus_phase_t locked_o,
    output logic       mismatch_o
);
    bus_phase_t locked_q;

    always_ff @(posedge clk) begin
        if (rst)
            locked_q <= '0;
        else if (capture)
            locked_q <= phase_in;
    end

    assign locked_o   = locked_q;
    assign mismatch_o = (phase_in != locked_q);

    AST_LOCK_HELD: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(locked_q)); // R5

endmodule

// File: rtl/scsi_init_xfer.sv
module scsi_init_xfer
    import scsi_xfer_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int TIMEOUT_CYC = 750_000_000,
    parameter int SETTLE_CYC  = 100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             dir_rx,
    input  logic [CNT_W-1:0] xfer_len,
    input  logic [7:0]       tx_data,
    output logic             tx_take,
    output logic [7:0]       rx_data,
    output logic             rx_valid,
    input  logic [7:0]       bus_db_in,
    output logic [7:0]       bus_db_out,
    output logic             bus_db_oe,
    input  logic [2:0]       bus_phase,
    input  logic             bus_req,
    input  logic             bus_rst,
    output logic             bus_ack,
    output logic             bus_atn,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] xfer_count,
    output logic             err_phase,
    output logic             err_timeout
);
    xfer_state_e      state_q, state_n;
    end_cause_e       cause;
    xfer_status_t     stat_q;
    logic             finish;
    logic             dir_q, ack_q, atn_q, done_q, rxv_q, take_q;
    logic [CNT_W-1:0] len_q, cnt_q;
    logic [7:0]       rxd_q;
    logic             waiting, last_byte, byte_done, launch;
    logic             tmo_exp, settle_exp, ph_bad;
    bus_phase_t       ph_locked;

    assign waiting   = (state_q == XS_WAIT_HI) || (state_q == XS_WAIT_LO);
    assign last_byte = ((cnt_q + 1'b1) == len_q);
    assign launch    = (state_q == XS_IDLE) && start;
    assign byte_done = (state_q == XS_WAIT_LO) && !bus_rst && !bus_req;

    scsi_xfer_phase_lock u_lock (
        .clk       (clk),
        .rst       (rst),
        .capture   (launch),
        .phase_in  (bus_phase),
        .locked_o  (ph_locked),
        .mismatch_o(ph_bad)
    );

    scsi_xfer_timer #(.LIMIT(TIMEOUT_CYC)) u_req_tmo (
        .clk    (clk),
        .rst    (rst),
        .clear  (!waiting || (state_n != state_q)),
        .run    (waiting),
        .expired(tmo_exp)
    );

    scsi_xfer_timer #(.LIMIT(SETTLE_CYC)) u_settle (
        .clk    (clk),
        .rst    (rst),
        .clear  (state_q != XS_SETTLE),
        .run    (state_q == XS_SETTLE),
        .expired(settle_exp)
    );

    always_comb begin
        state_n = state_q;
        finish  = 1'b0;
        cause   = END_OK;
        unique case (state_q)
            XS_IDLE: begin
                if (start) begin
                    if (xfer_len == '0) finish = 1'b1;
                    else                state_n = XS_WAIT_HI;
                end
            end
            XS_WAIT_HI: begin
                if (bus_rst) begin
                    finish = 1'b1; cause = END_TIMEOUT;
                end else if (bus_req) begin
                    if (ph_bad) begin
                        finish = 1'b1; cause = END_PHASE;
                    end else begin
                        state_n = dir_q ? XS_SETTLE : XS_WAIT_LO;
                    end
                end else if (tmo_exp) begin
                    finish = 1'b1; cause = END_TIMEOUT;
                end
            end
            XS_SETTLE: begin
                if (bus_rst) begin
                    finish = 1'b1; cause = END_TIMEOUT;
                end else if (settle_exp) begin
                    state_n = XS_WAIT_LO;
                end
            end
            XS_WAIT_LO: begin
                if (bus_rst) begin
                    finish = 1'b1; cause = END_TIMEOUT;
                end else if (!bus_req) begin
                    if (last_byte) begin
                        finish = 1'b1;
                    end else if (ph_bad) begin
                        finish = 1'b1; cause = END_PHASE;
                    end else begin
                        state_n = XS_WAIT_HI;
                    end
                end else if (tmo_exp) begin
                    finish = 1'b1; cause = END_TIMEOUT;
                end
            end
            default: state_n = XS_IDLE;
        endcase
        if (finish) state_n = XS_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= XS_IDLE;
            stat_q  <= '0;
            dir_q   <= 1'b0;
            ack_q   <= 1'b0;
            atn_q   <= 1'b0;
            done_q  <= 1'b0;
            rxv_q   <= 1'b0;
            take_q  <= 1'b0;
            len_q   <= '0;
            cnt_q   <= '0;
            rxd_q   <= '0;
        end else begin
            state_q <= state_n;
            done_q  <= finish;
            ack_q   <= (state_n == XS_WAIT_LO);
            rxv_q   <= 1'b0;
            take_q  <= 1'b0;
            if (launch) begin
                dir_q  <= dir_rx;
                len_q  <= xfer_len;
                cnt_q  <= '0;
                stat_q <= '0;
                atn_q  <= (xfer_len != '0) && owns_atn(dir_rx, bus_phase);
            end
            if ((state_q == XS_SETTLE) && (state_n == XS_WAIT_LO)) begin
                rxd_q <= bus_db_in;
                rxv_q <= 1'b1;
            end
            if (byte_done) begin
                cnt_q  <= cnt_q + 1'b1;
                take_q <= !dir_q;
            end
            if ((state_q == XS_WAIT_HI) && bus_req && !bus_rst && last_byte)
                atn_q <= 1'b0;
            if (finish) begin
                atn_q  <= 1'b0;
                stat_q <= '{err_phase:   (cause == END_PHASE),
                            err_timeout: (cause == END_TIMEOUT)};
            end
        end
    end

    assign busy        = (state_q != XS_IDLE);
    assign done        = done_q;
    assign bus_ack     = ack_q;
    assign bus_atn     = atn_q;
    assign bus_db_oe   = busy && !dir_q;
    assign bus_db_out  = bus_db_oe ? tx_data : 8'h00;
    assign rx_data     = rxd_q;
    assign rx_valid    = rxv_q;
    assign tx_take     = take_q;
    assign xfer_count  = cnt_q;
    assign err_phase   = stat_q.err_phase;
    assign err_timeout = stat_q.err_timeout;

    AST_ACK_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !bus_ack); // R9
    AST_SEND_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_ack) && bus_db_oe |-> $past(bus_req)); // R3
    AST_ATN_GONE_LAST_ACK: assert property (@(posedge clk) disable iff (rst)
        bus_ack && last_byte |-> !bus_atn); // R7
    AST_ONE_ERROR: assert property (@(posedge clk) disable iff (rst)
        !(err_phase && err_timeout)); // R12
    AST_COUNT_BELOW_LEN: assert property (@(posedge clk) disable iff (rst)
        busy |-> (xfer_count < len_q)); // R4
    AST_PHASE_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(err_phase) |-> done); // R5

endmodule

// File: tb/scsi_init_xfer_tb.sv
module scsi_init_xfer_tb_top;

    localparam int CNT_W   = 8;
    localparam int TMO     = 40;
    localparam int SETTLE  = 3;

    typedef struct packed {
        logic       rx;
        logic [2:0] ph;
        logic [7:0] n;
        logic [7:0] bad;
        logic       post;
        logic [7:0] exp_cnt;
        logic       exp_perr;
    } vec_t;

    localparam vec_t VECS [0:8] = '{
        '{1'b1, 3'b001, 8'd4, 8'd255, 1'b0, 8'd4, 1'b0},
        '{1'b0, 3'b000, 8'd5, 8'd255, 1'b0, 8'd5, 1'b0},
        '{1'b0, 3'b110, 8'd3, 8'd255, 1'b0, 8'd3, 1'b0},
        '{1'b1, 3'b011, 8'd1, 8'd255, 1'b0, 8'd1, 1'b0},
        '{1'b1, 3'b001, 8'd6, 8'd2,   1'b0, 8'd2, 1'b1},
        '{1'b0, 3'b000, 8'd5, 8'd3,   1'b1, 8'd3, 1'b1},
        '{1'b0, 3'b000, 8'd4, 8'd0,   1'b0, 8'd0, 1'b1},
        '{1'b1, 3'b111, 8'd2, 8'd255, 1'b0, 8'd2, 1'b0},
        '{1'b0, 3'b110, 8'd1, 8'd255, 1'b0, 8'd1, 1'b0}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic             dir_rx = 1'b0;
    logic [CNT_W-1:0] xfer_len = '0;
    logic [7:0]       tx_data;
    logic             tx_take;
    logic [7:0]       rx_data;
    logic             rx_valid;
    logic [7:0]       bus_db_in = '0;
    logic [7:0]       bus_db_out;
    logic             bus_db_oe;
    logic [2:0]       bus_phase = '0;
    logic             bus_req = 1'b0;
    logic             bus_rst = 1'b0;
    logic             bus_ack, bus_atn, busy, done;
    logic [CNT_W-1:0] xfer_count;
    logic             err_phase, err_timeout;

    int n_checks = 0;
    int n_fail   = 0;
    int take_total = 0;
    int rx_total   = 0;
    int done_total = 0;

    always #2 clk = ~clk;

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37) + 8'h5A);
    endfunction

    assign tx_data = pat(take_total);

    scsi_init_xfer #(.CNT_W(CNT_W), .TIMEOUT_CYC(TMO), .SETTLE_CYC(SETTLE)) dut_i (
        .clk(clk), .rst(rst), .start(start), .dir_rx(dir_rx), .xfer_len(xfer_len),
        .tx_data(tx_data), .tx_take(tx_take), .rx_data(rx_data), .rx_valid(rx_valid),
        .bus_db_in(bus_db_in), .bus_db_out(bus_db_out), .bus_db_oe(bus_db_oe),
        .bus_phase(bus_phase), .bus_req(bus_req), .bus_rst(bus_rst),
        .bus_ack(bus_ack), .bus_atn(bus_atn), .busy(busy), .done(done),
        .xfer_count(xfer_count), .err_phase(err_phase), .err_timeout(err_timeout)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (tx_take)  take_total <= take_total + 1;
            if (rx_valid) rx_total   <= rx_total + 1;
            if (done)     done_total <= done_total + 1;
        end
    end

    task automatic check_eq(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    endtask

    task automatic kick(input logic rx, input logic [2:0] ph, input int n);
        @(negedge clk);
        dir_rx = rx; bus_phase = ph; xfer_len = CNT_W'(n); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_vec(input vec_t v, input int id);
        int base_take, base_rx, base_done, waits;
        logic msgout;
        base_take = take_total; base_rx = rx_total; base_done = done_total;
        msgout = !v.rx && (v.ph == 3'b110);
        kick(v.rx, v.ph, int'(v.n));
        if (msgout) check_eq($sformatf("R7 vec%0d atn at start", id), int'(bus_atn), 1);
        if (!v.rx)  check_eq($sformatf("R3 vec%0d db_oe", id), int'(bus_db_oe), 1);
        for (int b = 0; b < int'(v.n); b++) begin
            if (!busy) break;
            bus_db_in = pat(b + 100);
            if (!v.post && (b == int'(v.bad))) bus_phase = v.ph ^ 3'b100;
            bus_req = 1'b1;
            waits = 0;
            do begin @(negedge clk); waits++; end while (!bus_ack && busy && waits < 200);
            if (!bus_ack) break;
            if (v.rx) begin
                check_eq($sformatf("R2 vec%0d b%0d ack delay", id, b), waits, SETTLE + 1);
                check_eq($sformatf("R2 vec%0d b%0d rx_data", id, b), int'(rx_data), int'(pat(b + 100)));
            end else begin
                check_eq($sformatf("R3 vec%0d b%0d ack delay", id, b), waits, 1);
                check_eq($sformatf("R3 vec%0d b%0d db_out", id, b), int'(bus_db_out), int'(pat(base_take + b)));
            end
            if (msgout)
                check_eq($sformatf("R7 vec%0d b%0d atn", id, b), int'(bus_atn), (b != int'(v.n) - 1) ? 1 : 0);
            bus_req = 1'b0;
            if (v.post && (b + 1 == int'(v.bad))) bus_phase = v.ph ^ 3'b100;
            waits = 0;
            do begin @(negedge clk); waits++; end while (bus_ack && waits < 200);
            check_eq($sformatf("R4 vec%0d b%0d ack release", id, b), waits, 1);
        end
        bus_req = 1'b0;
        for (int w = 0; w < 200 && busy; w++) @(negedge clk);
        repeat (3) @(negedge clk);
        check_eq($sformatf("R12 vec%0d count", id), int'(xfer_count), int'(v.exp_cnt));
        check_eq($sformatf("%s vec%0d err_phase", v.post ? "R6" : "R5", id), int'(err_phase), int'(v.exp_perr));
        check_eq($sformatf("R12 vec%0d err_timeout", id), int'(err_timeout), 0);
        check_eq($sformatf("R11 vec%0d done pulses", id), done_total - base_done, 1);
        check_eq($sformatf("R4 vec%0d ack idle", id), int'(bus_ack), 0);
        if (v.rx) check_eq($sformatf("R2 vec%0d rx strobes", id), rx_total - base_rx, int'(v.exp_cnt));
        else      check_eq($sformatf("R3 vec%0d take strobes", id), take_total - base_take, int'(v.exp_cnt));
        bus_phase = v.ph;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R11 watchdog: actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check_eq("R1 ack", int'(bus_ack), 0);
        check_eq("R1 atn", int'(bus_atn), 0);
        check_eq("R1 db_oe", int'(bus_db_oe), 0);
        check_eq("R1 busy", int'(busy), 0);
        check_eq("R1 flags", int'({err_phase, err_timeout, done}), 0);
        check_eq("R1 count", int'(xfer_count), 0);

        // R8: no REQ at all
        kick(1'b1, 3'b001, 2);
        repeat (30) @(negedge clk);
        check_eq("R8 still waiting", int'(busy), 1);
        repeat (15) @(negedge clk);
        check_eq("R8 ended", int'(busy), 0);
        check_eq("R8 err_timeout", int'(err_timeout), 1);
        check_eq("R8 err_phase", int'(err_phase), 0);
        check_eq("R8 count", int'(xfer_count), 0);

        // R9: REQ stuck high after ACK
        kick(1'b0, 3'b000, 2);
        bus_req = 1'b1;
        @(negedge clk);
        check_eq("R9 ack raised", int'(bus_ack), 1);
        repeat (45) @(negedge clk);
        check_eq("R9 ack dropped", int'(bus_ack), 0);
        check_eq("R9 busy", int'(busy), 0);
        check_eq("R9 err_timeout", int'(err_timeout), 1);
        check_eq("R9 count", int'(xfer_count), 0);
        bus_req = 1'b0;
        @(negedge clk);

        // R10: bus reset aborts a wait
        kick(1'b1, 3'b001, 3);
        repeat (5) @(negedge clk);
        bus_rst = 1'b1;
        @(negedge clk);
        check_eq("R10 busy", int'(busy), 0);
        check_eq("R10 err_timeout", int'(err_timeout), 1);
        check_eq("R10 ack", int'(bus_ack), 0);
        bus_rst = 1'b0;
        @(negedge clk);

        // R11: zero-length start
        begin
            int d0;
            d0 = done_total;
            kick(1'b0, 3'b000, 0);
            check_eq("R11 zero done", int'(done), 1);
            check_eq("R11 zero busy", int'(busy), 0);
            check_eq("R11 zero flags", int'({err_phase, err_timeout}), 0);
            @(negedge clk);
            check_eq("R11 zero single pulse", done_total - d0, 1);
            check_eq("R7 zero atn", int'(bus_atn), 0);
        end

        for (int i = 0; i < 9; i++) run_vec(VECS[i], i);

        summary();
        $finish;
    end

endmodule